// File: doc/BRIEF.md
# Block-Floating-Point Stage Scaler

This block keeps a transform engine's intermediate data inside its word length without giving up the precision of a fixed scale. Several butterfly output lanes are watched for the whole of one pass (a stage). Each lane presents only the three most significant bits of its wider result, and each is graded as needing no extra headroom, one bit or two bits. The worst grade seen anywhere in the stage is held. When the stage closes, that grade becomes the right-shift count applied to every operand read in the following stage. The same grade is also added into a saturating group exponent, which travels with the final result as its common scale.

A controller pulses `xform_start` once per transform, `stage_begin` at the start of each pass and `stage_done` on the last cycle of the pass. Samples on lanes whose valid bit is low take no part. The shift count and the exponent are registered and change only on the clock edge that follows a `stage_done` or `xform_start`.

Top module: `bfp_scaler`

## Requirements
- R1: While reset is asserted and after its release, `shift_amt` reads 0 and `grp_exp` reads 0.
- R2: A lane's three top bits (bit 2 being the MSB) are graded 0 when all three are equal (000, 111), 1 for 001 or 110, and 2 when bit 2 differs from bit 1 (010, 011, 100, 101).
- R3: Within a stage the held grade never decreases; it is the maximum grade over all valid samples of all lanes in the stage, whatever their order.
- R4: A `stage_begin` pulse discards the grade held from earlier samples, and so does a `stage_done` pulse for the stage that follows it.
- R5: On the edge after `stage_done`, `shift_amt` takes the stage's maximum grade and keeps it until the next `stage_done` or `xform_start`.
- R6: On the edge after `stage_done`, `grp_exp` increases by that same maximum grade.
- R7: `grp_exp` saturates at 2^EXP_W-1 (31 by default) and never wraps.
- R8: `xform_start` clears `shift_amt`, `grp_exp` and the held grade on the next edge and takes priority over a `stage_done` in the same cycle.
- R9: A lane whose bit in `smp_valid` is low has no effect, whatever its top bits are.
- R10: A valid sample presented in the same cycle as `stage_done` is included in that stage's grade.
- R11: A valid sample presented in the same cycle as `stage_begin` counts toward the new stage.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| xform_start | input | 1 | Start of a new transform; clears shift and exponent |
| stage_begin | input | 1 | Start of a stage; clears the held grade |
| stage_done | input | 1 | Last cycle of a stage; commits the grade |
| smp_valid | input | LANES (4) | Per-lane sample valid |
| smp_top | input | 3*LANES (12) | Three MSBs of each lane's butterfly output, lane 0 in bits 2:0 |
| shift_amt | output | 2 | Right-shift count for the next stage's input data |
| grp_exp | output | EXP_W (5) | Accumulated group exponent |

## Verification
The assertions assume the controller pulses `stage_begin` and `stage_done` at most once per stage and that `smp_top` is meaningful only on lanes flagged valid. They accept any relation between the strobes within one cycle, since the priority among them is defined. The stimulus holds every strobe for exactly one cycle, drives invalid lanes with overflowing patterns to expose a missing qualification, and drives the same-cycle overlaps of sample with `stage_begin`, sample with `stage_done`, and `xform_start` with `stage_done` on purpose.

// File: rtl/bfp_pkg.sv
package bfp_pkg;

  // Overflow grade of one butterfly result, ordered by headroom needed.
  typedef enum logic [1:0] {
    OVF_NONE = 2'd0,
    OVF_ONE  = 2'd1,
    OVF_TWO  = 2'd2
  } ovf_e;

  localparam int TOP_W   = 3;
  localparam int SHIFT_W = 2;

  function automatic ovf_e ovf_max(input ovf_e a, input ovf_e b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/bfp_ovf_grade.sv
module bfp_ovf_grade
  import bfp_pkg::*;
(
  input  logic [TOP_W-1:0] top_i,
  input  logic             valid_i,
  output ovf_e             grade_o
);

  logic sign_diff;
  logic low_diff;

  always_comb begin
    sign_diff = top_i[2] ^ top_i[1];
    low_diff  = top_i[1] ^ top_i[0];
    if (!valid_i) begin
      grade_o = OVF_NONE;
    end else if (sign_diff) begin
      grade_o = OVF_TWO;
    end else if (low_diff) begin
      grade_o = OVF_ONE;
    end else begin
      grade_o = OVF_NONE;
    end
  end

endmodule

// File: rtl/bfp_ovf_tracker.sv
module bfp_ovf_tracker
  import bfp_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic restart_i,
  input  logic commit_i,
  input  ovf_e grade_i,
  output ovf_e commit_grade_o
);

  ovf_e det_q;
  ovf_e det_nxt;
  ovf_e merged;

  always_comb begin
    merged = ovf_max(det_q, grade_i);
    if (restart_i) begin
      det_nxt = grade_i;
    end else if (commit_i) begin
      det_nxt = OVF_NONE;
    end else begin
      det_nxt = merged;
    end
  end

  assign commit_grade_o = merged;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      det_q <= OVF_NONE;
    end else begin
      det_q <= det_nxt;
    end
  end

  // Held grade is monotonic inside a stage
  assert_grade_monotonic_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!restart_i && !commit_i) |=> (det_q >= $past(det_q)));

  // Restart with no valid overflow leaves a clean detector
  assert_restart_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (restart_i && grade_i == OVF_NONE) |=> (det_q == OVF_NONE));

endmodule

// File: rtl/bfp_scale_acc.sv
module bfp_scale_acc
  import bfp_pkg::*;
#(
  parameter int EXP_W = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr_i,
  input  logic               commit_i,
  input  ovf_e               grade_i,
  output logic [SHIFT_W-1:0] shift_o,
  output logic [EXP_W-1:0]   exp_o
);

  localparam logic [EXP_W-1:0] EXP_MAX = '1;

  logic [SHIFT_W-1:0] shift_q, shift_nxt;
  logic [EXP_W-1:0]   exp_q, exp_nxt;
  logic [EXP_W:0]     exp_sum;
  logic               upd_en;

  always_comb begin
    upd_en    = clr_i | commit_i;
    exp_sum   = {1'b0, exp_q} + (EXP_W+1)'(grade_i);
    shift_nxt = shift_q;
    exp_nxt   = exp_q;
    if (clr_i) begin
      shift_nxt = '0;
      exp_nxt   = '0;
    end else if (commit_i) begin
      shift_nxt = SHIFT_W'(grade_i);
      exp_nxt   = exp_sum[EXP_W] ? EXP_MAX : exp_sum[EXP_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shift_q <= '0;
      exp_q   <= '0;
    end else if (upd_en) begin
      shift_q <= shift_nxt;
      exp_q   <= exp_nxt;
    end
  end

  assign shift_o = shift_q;
  assign exp_o   = exp_q;

  // Exponent grows by exactly the committed shift, or pins at its ceiling
  assert_exp_tracks_shift_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_i && !clr_i) |=> ((exp_q == EXP_MAX) || (exp_q == $past(exp_q) + EXP_W'(shift_q))));

  // Exponent never wraps downward except on transform start
  assert_exp_no_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_i |=> (exp_q >= $past(exp_q)));

  // Transform start clears both outputs
  assert_xform_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (shift_q == '0 && exp_q == '0));

  // Shift holds between commits
  assert_shift_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && !commit_i) |=> $stable(shift_q));

endmodule

// File: rtl/bfp_scaler.sv
module bfp_scaler
  import bfp_pkg::*;
#(
  parameter int LANES = 4,
  parameter int EXP_W = 5
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   xform_start,
  input  logic                   stage_begin,
  input  logic                   stage_done,
  input  logic [LANES-1:0]       smp_valid,
  input  logic [TOP_W*LANES-1:0] smp_top,
  output logic [SHIFT_W-1:0]     shift_amt,
  output logic [EXP_W-1:0]       grp_exp
);

  ovf_e lane_grade [LANES];
  ovf_e cycle_grade;
  ovf_e stage_grade;
  logic restart;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    bfp_ovf_grade u_grade (
      .top_i   (smp_top[g*TOP_W +: TOP_W]),
      .valid_i (smp_valid[g]),
      .grade_o (lane_grade[g])
    );
  end

  always_comb begin
    cycle_grade = OVF_NONE;
    for (int i = 0; i < LANES; i++) begin
      cycle_grade = ovf_max(cycle_grade, lane_grade[i]);
    end
  end

  assign restart = xform_start | stage_begin;

  bfp_ovf_tracker u_tracker (
    .clk            (clk),
    .rst_n          (rst_n),
    .restart_i      (restart),
    .commit_i       (stage_done),
    .grade_i        (cycle_grade),
    .commit_grade_o (stage_grade)
  );

  bfp_scale_acc #(.EXP_W(EXP_W)) u_acc (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr_i    (xform_start),
    .commit_i (stage_done),
    .grade_i  (stage_grade),
    .shift_o  (shift_amt),
    .exp_o    (grp_exp)
  );

  // A committed shift is at least the grade of a sample in the commit cycle
  assert_done_sample_counts_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (stage_done && !xform_start && cycle_grade == OVF_TWO) |=> (shift_amt == 2'd2));

endmodule

// File: tb/bfp_scaler_bench.sv
module bfp_scaler_bench;

  localparam int LANES = 4;
  localparam int EXP_W = 5;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             xform_start = 1'b0;
  logic             stage_begin = 1'b0;
  logic             stage_done = 1'b0;
  logic [LANES-1:0] smp_valid = '0;
  logic [3*LANES-1:0] smp_top = '0;
  logic [1:0]       shift_amt;
  logic [EXP_W-1:0] grp_exp;

  int n_chk = 0;
  int n_bad = 0;
  int model_exp = 0;
  bit done_flag = 1'b0;

  always #4 clk = ~clk;

  bfp_scaler #(.LANES(LANES), .EXP_W(EXP_W)) u_bfp_scaler (
    .clk(clk), .rst_n(rst_n), .xform_start(xform_start), .stage_begin(stage_begin),
    .stage_done(stage_done), .smp_valid(smp_valid), .smp_top(smp_top),
    .shift_amt(shift_amt), .grp_exp(grp_exp)
  );

  // {valid[3:0], top lane3, lane2, lane1, lane0, expected grade}
  localparam logic [17:0] VEC [12] = '{
    {4'hF, 3'b000, 3'b000, 3'b000, 3'b000, 2'd0},
    {4'hF, 3'b111, 3'b111, 3'b111, 3'b111, 2'd0},
    {4'hF, 3'b000, 3'b000, 3'b001, 3'b000, 2'd1},
    {4'hF, 3'b110, 3'b111, 3'b000, 3'b111, 2'd1},
    {4'hF, 3'b000, 3'b010, 3'b001, 3'b000, 2'd2},
    {4'hF, 3'b111, 3'b000, 3'b000, 3'b011, 2'd2},
    {4'hF, 3'b110, 3'b000, 3'b100, 3'b000, 2'd2},
    {4'hF, 3'b101, 3'b001, 3'b000, 3'b000, 2'd2},
    {4'hE, 3'b000, 3'b000, 3'b000, 3'b010, 2'd0},
    {4'h4, 3'b101, 3'b001, 3'b100, 3'b111, 2'd1},
    {4'h0, 3'b001, 3'b010, 3'b101, 3'b110, 2'd0},
    {4'h3, 3'b010, 3'b011, 3'b101, 3'b110, 2'd2}
  };

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Drive one cycle of inputs after a falling edge, return 2 ns after the rising edge.
  task automatic step(input logic xs, input logic sb, input logic sd,
                      input logic [3:0] v, input logic [11:0] t);
    @(negedge clk);
    xform_start = xs; stage_begin = sb; stage_done = sd; smp_valid = v; smp_top = t;
    @(posedge clk);
    #2;
    xform_start = 1'b0; stage_begin = 1'b0; stage_done = 1'b0; smp_valid = '0; smp_top = '0;
  endtask

  function automatic int sat_add(input int a, input int b);
    return (a + b > 31) ? 31 : a + b;
  endfunction

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    chk("R1 shift in reset", shift_amt, 0);
    chk("R1 exp in reset", grp_exp, 0);
    @(negedge clk);
    rst_n = 1'b1;
    step(1'b0, 1'b0, 1'b0, 4'h0, 12'h0);
    chk("R1 shift after release", shift_amt, 0);
    chk("R1 exp after release", grp_exp, 0);

    step(1'b1, 1'b0, 1'b0, 4'h0, 12'h0);
    model_exp = 0;
    // R2 R3 R6 R9: table walk, one stage per vector
    foreach (VEC[k]) begin
      step(1'b0, 1'b1, 1'b0, 4'h0, 12'h0);
      step(1'b0, 1'b0, 1'b0, VEC[k][17:14], VEC[k][13:2]);
      step(1'b0, 1'b0, 1'b1, 4'h0, 12'h0);
      model_exp = sat_add(model_exp, int'(VEC[k][1:0]));
      chk($sformatf("R2/R9 vec %0d shift", k), shift_amt, int'(VEC[k][1:0]));
      chk($sformatf("R6 vec %0d exp", k), grp_exp, model_exp);
    end

    // R5: a stage without an end leaves the shift untouched
    step(1'b0, 1'b1, 1'b0, 4'h0, 12'h0);
    step(1'b0, 1'b0, 1'b0, 4'h1, 12'b000_000_000_000);
    chk("R5 shift held mid-stage", shift_amt, 2);
    chk("R5 exp held mid-stage", grp_exp, model_exp);

    // R8: transform start clears
    step(1'b1, 1'b0, 1'b0, 4'h0, 12'h0);
    model_exp = 0;
    chk("R8 shift cleared", shift_amt, 0);
    chk("R8 exp cleared", grp_exp, 0);

    // R3: largest grade first, smaller ones later
    step(1'b0, 1'b1, 1'b0, 4'h0, 12'h0);
    step(1'b0, 1'b0, 1'b0, 4'h1, 12'b000_000_000_010);
    step(1'b0, 1'b0, 1'b0, 4'h2, 12'b000_000_001_000);
    step(1'b0, 1'b0, 1'b0, 4'hF, 12'h000);
    step(1'b0, 1'b0, 1'b1, 4'h0, 12'h0);
    model_exp = sat_add(model_exp, 2);
    chk("R3 max kept over later samples", shift_amt, 2);

    // R10: the only overflowing sample arrives with stage_done
    step(1'b0, 1'b1, 1'b0, 4'h0, 12'h0);
    step(1'b0, 1'b0, 1'b1, 4'h8, 12'b110_000_000_000);
    model_exp = sat_add(model_exp, 1);
    chk("R10 sample with done counted", shift_amt, 1);
    chk("R10 exp", grp_exp, model_exp);

    // R4 R11: earlier overflow discarded by stage_begin, sample on begin counts
    step(1'b0, 1'b0, 1'b0, 4'h1, 12'b000_000_000_100);
    step(1'b0, 1'b1, 1'b0, 4'h2, 12'b000_000_001_000);
    step(1'b0, 1'b0, 1'b1, 4'h0, 12'h0);
    model_exp = sat_add(model_exp, 1);
    chk("R4/R11 begin clears, begin sample counts", shift_amt, 1);

    // R4: stage_done alone resets the held grade for the next stage
    step(1'b0, 1'b0, 1'b0, 4'h1, 12'b000_000_000_011);
    step(1'b0, 1'b0, 1'b1, 4'h0, 12'h0);
    model_exp = sat_add(model_exp, 2);
    chk("R4 pre stage", shift_amt, 2);
    step(1'b0, 1'b0, 1'b0, 4'hF, 12'hFFF);
    step(1'b0, 1'b0, 1'b1, 4'h0, 12'h0);
    chk("R4 done resets detector", shift_amt, 0);
    chk("R4 exp unchanged", grp_exp, model_exp);

    // R8: xform_start beats stage_done
    step(1'b0, 1'b1, 1'b0, 4'h1, 12'b000_000_000_010);
    step(1'b1, 1'b0, 1'b1, 4'h0, 12'h0);
    model_exp = 0;
    chk("R8 priority shift", shift_amt, 0);
    chk("R8 priority exp", grp_exp, 0);

    // R7: saturation after 16 stages of grade 2
    for (int s = 0; s < 16; s++) begin
      step(1'b0, 1'b1, 1'b0, 4'h4, 12'b000_101_000_000);
      step(1'b0, 1'b0, 1'b1, 4'h0, 12'h0);
      model_exp = sat_add(model_exp, 2);
    end
    chk("R7 exp saturated", grp_exp, 31);
    chk("R7 model agrees", grp_exp, model_exp);
    step(1'b0, 1'b1, 1'b1, 4'h1, 12'b000_000_000_001);
    chk("R7 no wrap", grp_exp, 31);

    finish_run();
  end

endmodule